// File: doc/BRIEF.md
# Shadowed Static Memory Store/Recall Controller

This block models a byte-wide static working memory paired with a nonvolatile shadow array of the same size. Outside a transfer it behaves like an ordinary static memory driven by active-low chip enable, output enable and write enable strobes. A write is captured from the address and data present on its last active cycle, and it lands in the working array when either strobe releases.

The block also sequences whole-array transfers. A store copies every working byte into the shadow. A recall copies the shadow back, and one runs automatically after every reset before any access is accepted. A store can be started by an active-low hardware store line, by a one-cycle software request, or by a power-fail comparator input. Hardware and power-fail stores only run when the working array holds data written since the last transfer. While any transfer runs, the active-low status output is held low and the array ignores all accesses.

The store and recall windows are cycle counts set by parameters. The default store window is about 10 ms at a 50 MHz clock. The power-fail trigger can be inhibited by a mode input, which is captured only while reset is held.

Top module: `nvshadow_ram`

## Requirements
- R1: While `rst_n` is low, and for exactly RECALL_CYCLES clock cycles after it is released, `busy_n` is low. At the end of that window the working array holds the shadow contents.
- R2: `dout_en` is high, with `dout` showing the working byte at `addr`, only when `ce_n`=0, `oe_n`=0, `we_n`=1, `hs_n`=1 and no transfer runs. In every other case `dout_en` is 0.
- R3: A write is active while `ce_n`=0, `we_n`=0 and `hs_n`=1 with no transfer running. The `addr`/`din` of its last active cycle are written when `ce_n` or `we_n` rises, and the write sets `dirty` to 1.
- R4: Whenever `we_n` is 0, `dout_en` is 0, even with `oe_n` low.
- R5: A one-cycle high on `sw_store` while idle always starts a store, even with `dirty`=0. `busy_n` is then low for exactly STORE_CYCLES cycles, after which the shadow equals the working array.
- R6: `hs_n`=0 while idle starts a store only if `dirty`=1. Otherwise it has no effect.
- R7: `pwr_ok`=0 while idle starts a store only if `dirty`=1 and the power-fail trigger is not inhibited.
- R8: `inhibit_auto`=1, as captured during reset, disables the power-fail trigger and leaves the hardware and software triggers working.
- R9: While `busy_n` is low, write attempts change neither the working array nor `dirty`, and `dout_en` stays 0.
- R10: Triggers that arrive together produce a single store window, chosen in the order power-fail, hardware, software. A request that arrives during a transfer is dropped.
- R11: `dirty` is 0 when any store or recall completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; a recall follows its release |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| hs_n | input | 1 | Hardware store line, active low; must be high for accesses |
| sw_store | input | 1 | Pre-decoded software store request, active high |
| pwr_ok | input | 1 | Supply comparator; low means the supply is below threshold |
| inhibit_auto | input | 1 | High disables the power-fail store; captured during reset |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, zero when not driving |
| dout_en | output | 1 | Output driver enable |
| busy_n | output | 1 | Low while a store or recall runs |
| dirty | output | 1 | A write has completed since the last transfer |

## Verification
The bench builds the block with a 16-byte array, a 12-cycle store window and a 5-cycle recall window. At these sizes every location can be written and read back, and store windows can be counted one cycle at a time. Transfers can be started again and again within the run, so the bench reaches requests that collide inside a window, simultaneous triggers, and a second reset that recalls earlier stored data with the power-fail trigger inhibited.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [1:0] {
        ST_RECALL = 2'd0,
        ST_IDLE   = 2'd1,
        ST_STORE  = 2'd2
    } nvs_state_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_PWR  = 2'd1,
        SRC_HW   = 2'd2,
        SRC_SW   = 2'd3
    } nvs_src_e;

endpackage

// File: rtl/nvs_decode.sv
module nvs_decode (
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic hs_n,
    input  logic idle,
    output logic rd_en,
    output logic wr_en,
    output logic hs_req
);
    // Reads need the write strobe released, which also keeps the drivers
    // off for the whole time a write strobe is low.
    always_comb begin
        rd_en  = idle && !ce_n && !oe_n && we_n && hs_n;
        wr_en  = idle && !ce_n && !we_n && hs_n;
        hs_req = idle && !hs_n;
    end
endmodule

// File: rtl/nvs_trig.sv
module nvs_trig
    import nvs_pkg::*;
(
    input  logic     idle,
    input  logic     dirty,
    input  logic     hs_req,
    input  logic     sw_req,
    input  logic     pf_low,
    input  logic     auto_dis,
    output nvs_src_e src,
    output logic     go
);
    always_comb begin
        src = SRC_NONE;
        if (idle) begin
            if (pf_low && !auto_dis && dirty) begin
                src = SRC_PWR;
            end else if (hs_req && dirty) begin
                src = SRC_HW;
            end else if (sw_req) begin
                src = SRC_SW;
            end
        end
        go = (src != SRC_NONE);
    end
endmodule

// File: rtl/nvs_seq.sv
module nvs_seq
    import nvs_pkg::*;
#(
    parameter int ADDR_W        = 6,
    parameter int DATA_W        = 8,
    parameter int STORE_CYCLES  = 500000,
    parameter int RECALL_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inhibit,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              go,
    output logic              idle,
    output logic              dirty,
    output logic              auto_dis,
    output logic              commit,
    output logic [ADDR_W-1:0] cm_addr,
    output logic [DATA_W-1:0] cm_data,
    output logic              store_done,
    output logic              recall_done
);
    localparam int MAX_C = (STORE_CYCLES > RECALL_CYCLES) ? STORE_CYCLES : RECALL_CYCLES;
    localparam int CNT_W = $clog2(MAX_C + 1);
    localparam logic [CNT_W-1:0] STORE_LAST  = CNT_W'(STORE_CYCLES - 1);
    localparam logic [CNT_W-1:0] RECALL_LAST = CNT_W'(RECALL_CYCLES - 1);

    typedef struct packed {
        nvs_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic              dirty;
        logic              wr_act;
        logic [ADDR_W-1:0] wa;
        logic [DATA_W-1:0] wd;
        logic              auto_dis;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d       = seq_q;
        commit      = 1'b0;
        store_done  = 1'b0;
        recall_done = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                // end of a write: either strobe has released
                commit       = seq_q.wr_act && !wr_en;
                seq_d.wr_act = wr_en;
                if (wr_en) begin
                    seq_d.wa = addr;
                    seq_d.wd = din;
                end
                if (commit) begin
                    seq_d.dirty = 1'b1;
                end
                if (go) begin
                    seq_d.st     = ST_STORE;
                    seq_d.cnt    = '0;
                    seq_d.wr_act = 1'b0;
                end
            end
            ST_STORE: begin
                seq_d.wr_act = 1'b0;
                if (seq_q.cnt == STORE_LAST) begin
                    store_done  = 1'b1;
                    seq_d.st    = ST_IDLE;
                    seq_d.dirty = 1'b0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: begin
                seq_d.wr_act = 1'b0;
                if (seq_q.cnt == RECALL_LAST) begin
                    recall_done = 1'b1;
                    seq_d.st    = ST_IDLE;
                    seq_d.dirty = 1'b0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_RECALL, cnt: '0, dirty: 1'b0, wr_act: 1'b0,
                       wa: '0, wd: '0, auto_dis: inhibit};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign idle     = (seq_q.st == ST_IDLE);
    assign dirty    = seq_q.dirty;
    assign auto_dis = seq_q.auto_dis;
    assign cm_addr  = seq_q.wa;
    assign cm_data  = seq_q.wd;
endmodule

// File: rtl/nvs_array.sv
module nvs_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              commit,
    input  logic [ADDR_W-1:0] cm_addr,
    input  logic [DATA_W-1:0] cm_data,
    input  logic              store_done,
    input  logic              recall_done,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] work_d [DEPTH];
    logic [DATA_W-1:0] work_q [DEPTH];
    logic [DATA_W-1:0] shd_d  [DEPTH];
    logic [DATA_W-1:0] shd_q  [DEPTH];

    // Whole-array parallel copies; no reset, the contents are the state.
    always_comb begin
        work_d = work_q;
        shd_d  = shd_q;
        if (recall_done) begin
            work_d = shd_q;
        end
        if (commit) begin
            work_d[cm_addr] = cm_data;
        end
        if (store_done) begin
            shd_d = work_q;
        end
    end

    always_ff @(posedge clk) begin
        work_q <= work_d;
        shd_q  <= shd_d;
    end

    assign rd_data = rd_en ? work_q[rd_addr] : '0;
endmodule

// File: rtl/nvshadow_ram.sv
module nvshadow_ram
    import nvs_pkg::*;
#(
    parameter int ADDR_W        = 6,
    parameter int DATA_W        = 8,
    parameter int STORE_CYCLES  = 500000,
    parameter int RECALL_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              hs_n,
    input  logic              sw_store,
    input  logic              pwr_ok,
    input  logic              inhibit_auto,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              busy_n,
    output logic              dirty
);
    logic              idle, rd_en, wr_en, hs_req, go, auto_dis;
    logic              commit, store_done, recall_done;
    logic [ADDR_W-1:0] cm_addr;
    logic [DATA_W-1:0] cm_data;
    nvs_src_e          src;

    nvs_decode u_dec (
        .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .hs_n(hs_n), .idle(idle),
        .rd_en(rd_en), .wr_en(wr_en), .hs_req(hs_req)
    );

    nvs_trig u_trig (
        .idle(idle), .dirty(dirty), .hs_req(hs_req), .sw_req(sw_store),
        .pf_low(!pwr_ok), .auto_dis(auto_dis), .src(src), .go(go)
    );

    nvs_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .STORE_CYCLES(STORE_CYCLES), .RECALL_CYCLES(RECALL_CYCLES)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .inhibit(inhibit_auto), .wr_en(wr_en),
        .addr(addr), .din(din), .go(go), .idle(idle), .dirty(dirty),
        .auto_dis(auto_dis), .commit(commit), .cm_addr(cm_addr),
        .cm_data(cm_data), .store_done(store_done), .recall_done(recall_done)
    );

    nvs_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
        .clk(clk), .commit(commit), .cm_addr(cm_addr), .cm_data(cm_data),
        .store_done(store_done), .recall_done(recall_done),
        .rd_en(rd_en), .rd_addr(addr), .rd_data(dout)
    );

    assign dout_en = rd_en;
    assign busy_n  = idle;
endmodule

// File: rtl/nvs_chk.sv
module nvs_chk (
    input logic clk,
    input logic rst_n,
    input logic ce_n,
    input logic oe_n,
    input logic we_n,
    input logic hs_n,
    input logic sw_store,
    input logic pwr_ok,
    input logic dout_en,
    input logic busy_n,
    input logic dirty,
    input logic auto_dis
);
    assert_read_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> (!ce_n && !oe_n && we_n && hs_n && busy_n));

    assert_drv_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !dout_en);

    assert_dirty_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dirty) |-> $past(busy_n));

    assert_done_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_n) |-> !dirty);

    assert_sw_runs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_n && sw_store) |=> !busy_n);

    assert_clean_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_n && !dirty && !sw_store && (pwr_ok || auto_dis)) |=> busy_n);

    assert_pf_runs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_n && dirty && !pwr_ok && !auto_dis) |=> !busy_n);
endmodule

bind nvshadow_ram nvs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .hs_n(hs_n), .sw_store(sw_store), .pwr_ok(pwr_ok), .dout_en(dout_en),
    .busy_n(busy_n), .dirty(dirty), .auto_dis(auto_dis)
);

// File: tb/sim_nvshadow_ram.sv
module sim_nvshadow_ram;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;
    localparam int SC = 12;
    localparam int RC = 5;
    localparam int M_RECALL = 0;
    localparam int M_IDLE   = 1;
    localparam int M_STORE  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, hs_n = 1'b1;
    logic sw_store = 1'b0, pwr_ok = 1'b1, inhibit_auto = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic dout_en, busy_n, dirty;

    always #10 clk = ~clk;

    nvshadow_ram #(.ADDR_W(AW), .DATA_W(DW), .STORE_CYCLES(SC), .RECALL_CYCLES(RC)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .hs_n(hs_n), .sw_store(sw_store), .pwr_ok(pwr_ok),
        .inhibit_auto(inhibit_auto), .addr(addr), .din(din), .dout(dout),
        .dout_en(dout_en), .busy_n(busy_n), .dirty(dirty)
    );

    int total = 0;
    int bad = 0;
    string tag = "R1";

    // behavioural reference model
    int ref_work [DEPTH];
    bit ref_wv   [DEPTH];
    int ref_shd  [DEPTH];
    bit ref_sv   [DEPTH];
    int ref_mode = M_RECALL;
    int ref_cnt = 0;
    bit ref_dirty = 0, ref_wact = 0, ref_ad = 0, ref_init = 0;
    int ref_wa = 0, ref_wd = 0;

    task automatic chk(input bit ok, input string t, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: act=%0h exp=%0h at %0t", t, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit exp_en;
        if (ref_init) begin
            chk(busy_n == (ref_mode == M_IDLE), tag, busy_n, ref_mode == M_IDLE);
            chk(dirty == ref_dirty, tag, dirty, ref_dirty);
            exp_en = (ref_mode == M_IDLE) && !ce_n && !oe_n && we_n && hs_n;
            chk(dout_en == exp_en, tag, dout_en, exp_en);
            if (exp_en && ref_wv[addr]) chk(dout == ref_work[addr], tag, dout, ref_work[addr]);
        end
    endtask

    task automatic model_edge();
        bit wnow, cm, go;
        if (!rst_n) begin
            ref_mode = M_RECALL; ref_cnt = 0; ref_dirty = 0; ref_wact = 0;
            ref_ad = inhibit_auto; ref_init = 1;
        end else if (ref_mode == M_IDLE) begin
            wnow = !ce_n && !we_n && hs_n;
            cm = ref_wact && !wnow;
            if (cm) begin ref_work[ref_wa] = ref_wd; ref_wv[ref_wa] = 1; end
            go = sw_store || (!hs_n && ref_dirty) || (!pwr_ok && !ref_ad && ref_dirty);
            if (wnow) begin ref_wa = addr; ref_wd = din; end
            ref_wact = wnow;
            ref_dirty = ref_dirty || cm;
            if (go) begin ref_mode = M_STORE; ref_cnt = 0; ref_wact = 0; end
        end else if (ref_mode == M_STORE) begin
            if (ref_cnt == SC - 1) begin
                ref_shd = ref_work; ref_sv = ref_wv; ref_mode = M_IDLE; ref_dirty = 0;
            end else ref_cnt++;
        end else begin
            if (ref_cnt == RC - 1) begin
                ref_work = ref_shd; ref_wv = ref_sv; ref_mode = M_IDLE; ref_dirty = 0;
            end else ref_cnt++;
        end
    endtask

    // inputs are set at the falling edge; outputs checked 5 ns later
    task automatic tick();
        #5 compare();
        @(posedge clk);
        #1 model_edge();
        @(negedge clk);
    endtask

    task automatic quiet();
        ce_n = 1; oe_n = 1; we_n = 1; hs_n = 1; sw_store = 0; pwr_ok = 1;
    endtask

    task automatic wr(input int a, input int d);
        quiet(); ce_n = 0; we_n = 0; addr = AW'(a); din = DW'(d); tick();
        ce_n = 1; we_n = 1; tick();
    endtask

    task automatic rd_expect(input int a, input int e, input string t);
        quiet(); ce_n = 0; oe_n = 0; addr = AW'(a);
        #2 chk(dout_en == 1'b1 && dout == DW'(e), t, dout, e);
        tick(); quiet();
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (!busy_n && n < 1000) begin n++; tick(); end
    endtask

    function automatic int pat(input int i);
        return (i * 37 + 11) & 255;
    endfunction

    initial begin
        #(20 * 150000);
        bad++; total++;
        $display("FAIL watchdog: act=%0d exp=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        foreach (ref_wv[i]) begin ref_wv[i] = 0; ref_sv[i] = 0; ref_work[i] = 0; ref_shd[i] = 0; end
        @(negedge clk);
        // R1: reset holds busy, then a recall window of RC cycles
        tag = "R1"; rst_n = 0; quiet();
        tick(); tick(); tick();
        chk(busy_n == 1'b0, "R1", busy_n, 0);
        rst_n = 1;
        count_busy(n);
        chk(n == RC, "R1", n, RC);
        chk(dirty == 1'b0, "R11", dirty, 0);

        // R5: software store runs with a clean array
        tag = "R5"; sw_store = 1; tick(); sw_store = 0;
        count_busy(n);
        chk(n == SC, "R5", n, SC);

        // R3/R2: fill every location, read each back
        tag = "R3";
        for (int i = 0; i < DEPTH; i++) wr(i, pat(i));
        chk(dirty == 1'b1, "R3", dirty, 1);
        tag = "R2";
        for (int i = 0; i < DEPTH; i++) rd_expect(i, pat(i), "R2");
        // R3: address moves during a write; last active cycle wins, ended by ce_n
        tag = "R3"; quiet();
        ce_n = 0; we_n = 0; addr = 3; din = 8'hAA; tick();
        addr = 4; din = 8'hBB; tick();
        ce_n = 1; tick(); we_n = 1; tick();
        rd_expect(4, 8'hBB, "R3");
        rd_expect(3, pat(3), "R3");

        // R4: output enable held low across a write
        tag = "R4"; quiet();
        ce_n = 0; oe_n = 0; we_n = 0; addr = 5; din = 8'h5C;
        #2 chk(dout_en == 1'b0, "R4", dout_en, 0);
        tick(); tick();
        we_n = 1; tick(); tick(); quiet();
        rd_expect(5, 8'h5C, "R4");

        // R6: hardware store while dirty, then no effect while clean
        tag = "R6"; hs_n = 0; tick(); hs_n = 1;
        count_busy(n);
        chk(n == SC, "R6", n, SC);
        hs_n = 0; tick(); tick(); tick();
        chk(busy_n == 1'b1, "R6", busy_n, 1);
        tag = "R2"; ce_n = 0; oe_n = 0;
        #2 chk(dout_en == 1'b0, "R2", dout_en, 0);
        tick(); quiet();

        // R7: power-fail store while dirty, then ignored while clean
        tag = "R7"; wr(6, 8'h66);
        pwr_ok = 0; tick(); pwr_ok = 1;
        count_busy(n);
        chk(n == SC, "R7", n, SC);
        pwr_ok = 0; tick(); tick(); tick();
        chk(busy_n == 1'b1, "R7", busy_n, 1);
        quiet();

        // R9: accesses during a transfer are blocked
        tag = "R9"; sw_store = 1; tick(); sw_store = 0;
        ce_n = 0; we_n = 0; addr = 7; din = 8'h77; tick(); tick();
        ce_n = 1; we_n = 1; tick();
        ce_n = 0; oe_n = 0;
        #2 chk(dout_en == 1'b0, "R9", dout_en, 0);
        tick(); quiet();
        count_busy(n);
        chk(dirty == 1'b0, "R9", dirty, 0);
        rd_expect(7, pat(7), "R9");

        // R10: simultaneous triggers give one window; a request mid-window is dropped
        tag = "R10"; wr(8, 8'h88);
        sw_store = 1; hs_n = 0; pwr_ok = 0; tick(); quiet();
        count_busy(n);
        chk(n == SC, "R10", n, SC);
        tick(); tick();
        chk(busy_n == 1'b1, "R10", busy_n, 1);
        sw_store = 1; tick(); sw_store = 0; tick(); tick();
        sw_store = 1; tick(); sw_store = 0;
        count_busy(n);
        chk(n == SC - 3, "R10", n, SC - 3);

        // R1/R11/R8: dirty overwrite, reset with inhibit, recall restores stored data
        tag = "R11"; wr(0, 8'h11);
        rst_n = 0; inhibit_auto = 1; tick(); tick();
        rst_n = 1; inhibit_auto = 0;
        count_busy(n);
        chk(n == RC, "R1", n, RC);
        chk(dirty == 1'b0, "R11", dirty, 0);
        rd_expect(0, pat(0), "R1");
        tag = "R8"; wr(9, 8'h99);
        pwr_ok = 0; tick(); tick(); tick();
        chk(busy_n == 1'b1, "R8", busy_n, 1);
        chk(dirty == 1'b1, "R8", dirty, 1);
        quiet(); hs_n = 0; tick(); hs_n = 1;
        count_busy(n);
        chk(n == SC, "R8", n, SC);
        tick(); tick();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule